// File: doc/BRIEF.md
# Strobed Shared-Bus Register Bank

This block sits on the receiving end of a narrow parallel port inside a glue-logic device. A host shares one 8-bit data bus among three control registers: system control, monitor control and clock/routing control. Each register has its own active-low select strobe. A separate active-low enable gates every capture, and a direction line marks the access as a write (0) or a read (1). The stored bits leave the block unchanged and drive relay, mute, phantom power, source select and monitor routing controls.

To write, the host places a byte on the bus, pulls the enable low, pulls one strobe low and then releases it. The register takes the bus value present when the strobe rises. Afterwards the host parks the bus at all ones. All control inputs idle high. Strobes, enable, direction and data all cross into the system clock through matched two-stage synchronizers. Rising edges are detected on the synchronized strobes, so the captured byte stays aligned with the edge that selects it.

Top module: `strobe_bank`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, all three outputs `sysCtl`, `monCtl` and `clkCtl` read 0x00.
- R2: A rising edge on `strobeN[i]` captures the byte on `busData` into register i, provided `busEnN` is low and `dirRead` is 0 at that edge. Index 0 is system control (`sysCtl`), index 1 is monitor control (`monCtl`) and index 2 is clock/routing control (`clkCtl`). The new value appears on the output no later than 4 clock cycles after the edge.
- R3: A capture into one register leaves the other two registers unchanged.
- R4: A strobe rising edge seen while `busEnN` is high changes no register.
- R5: A strobe rising edge seen while `dirRead` is 1 changes no register.
- R6: While every strobe stays high, changes on `busData` and `busEnN` never alter a stored value. This includes the bus returning to 0xFF after a write.
- R7: A capture takes the byte present at the strobe's rising edge. Neither the falling edge nor a byte driven earlier while the strobe was low is captured.
- R8: When two strobes rise in the same cycle, both registers take the same bus byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Shared host data bus |
| busEnN | input | 1 | Active-low enable that gates all captures |
| dirRead | input | 1 | Access direction, 0 = write, 1 = read |
| strobeN | input | 3 | Active-low register strobes: bit 0 system, bit 1 monitor, bit 2 clock/routing |
| sysCtl | output | 8 | Stored system control byte |
| monCtl | output | 8 | Stored monitor control byte |
| clkCtl | output | 8 | Stored clock/routing control byte |

## Verification
On every cycle, the assertions check that the outputs are zero right after reset. They also check that the outputs hold once the strobes have stayed high for four cycles, once the enable has stayed high for four cycles, or once the direction line has signalled read for four cycles. The captured value itself can only be shown by the bench's scenarios. The same holds for which register a strobe selects, for capture on the rising edge rather than the falling edge, and for a dual-strobe write loading the same byte into both targets.

// File: rtl/strobe_bank_pkg.sv
package strobe_bank_pkg;
  localparam int REG_COUNT = 3;
  localparam int SYS_IDX   = 0;
  localparam int MON_IDX   = 1;
  localparam int CLK_IDX   = 2;

  // Control-to-datapath command: one capture pulse per register.
  typedef struct packed {
    logic [REG_COUNT-1:0] load;
  } capCmd_t;
endpackage

// File: rtl/bank_sync.sv
module bank_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import strobe_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_COUNT-1:0] strobeN,
  input  logic                 busEnN,
  input  logic                 dirRead,
  output capCmd_t              cmd
);
  localparam int CW = REG_COUNT + 2;

  logic [CW-1:0]        ctlSync;
  logic [REG_COUNT-1:0] strobeSync;
  logic [REG_COUNT-1:0] strobePrev;
  logic                 enSyncN;
  logic                 dirSync;
  logic                 writeOk;

  // Idle levels are high; direction resets to "read" so nothing loads early.
  bank_sync #(.WIDTH(CW), .STAGES(SYNC_STAGES), .RESET_VAL({CW{1'b1}})) u_ctlSync (
    .clk (clk),
    .rstN(rstN),
    .din ({dirRead, busEnN, strobeN}),
    .dout(ctlSync)
  );

  assign strobeSync = ctlSync[REG_COUNT-1:0];
  assign enSyncN    = ctlSync[REG_COUNT];
  assign dirSync    = ctlSync[REG_COUNT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= '1;
    else       strobePrev <= strobeSync;
  end

  assign writeOk = !enSyncN && !dirSync;

  always_comb begin
    cmd.load = strobeSync & ~strobePrev & {REG_COUNT{writeOk}};
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import strobe_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             busData,
  input  capCmd_t                       cmd,
  output logic [REG_COUNT*DATA_W-1:0]   regFlat
);
  logic [DATA_W-1:0] dataSync;

  // Same depth as the strobe path keeps the byte aligned with its edge.
  bank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL({DATA_W{1'b1}})) u_dataSync (
    .clk (clk),
    .rstN(rstN),
    .din (busData),
    .dout(dataSync)
  );

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [DATA_W-1:0] store;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             store <= '0;
      else if (cmd.load[g])  store <= dataSync;
    end
    assign regFlat[g*DATA_W +: DATA_W] = store;
  end
endmodule

// File: rtl/strobe_bank.sv
module strobe_bank
  import strobe_bank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    busData,
  input  logic                 busEnN,
  input  logic                 dirRead,
  input  logic [REG_COUNT-1:0] strobeN,
  output logic [DATA_W-1:0]    sysCtl,
  output logic [DATA_W-1:0]    monCtl,
  output logic [DATA_W-1:0]    clkCtl
);
  capCmd_t                     cmd;
  logic [REG_COUNT*DATA_W-1:0] regFlat;

  bank_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobeN(strobeN),
    .busEnN (busEnN),
    .dirRead(dirRead),
    .cmd    (cmd)
  );

  bank_regs #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .busData(busData),
    .cmd    (cmd),
    .regFlat(regFlat)
  );

  assign sysCtl = regFlat[SYS_IDX*DATA_W +: DATA_W];
  assign monCtl = regFlat[MON_IDX*DATA_W +: DATA_W];
  assign clkCtl = regFlat[CLK_IDX*DATA_W +: DATA_W];
endmodule

// File: rtl/strobe_bank_chk.sv
module strobe_bank_chk #(
  parameter int DATA_W = 8,
  parameter int NSTB = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busEnN,
  input logic              dirRead,
  input logic [NSTB-1:0]   strobeN,
  input logic [DATA_W-1:0] sysCtl,
  input logic [DATA_W-1:0] monCtl,
  input logic [DATA_W-1:0] clkCtl
);
  logic [3*DATA_W-1:0] allRegs;
  logic [2:0] quietCnt, enHighCnt, readCnt;

  assign allRegs = {clkCtl, monCtl, sysCtl};

  // Saturating counts of consecutive samples in each "no capture possible" condition.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt  <= '0;
      enHighCnt <= '0;
      readCnt   <= '0;
    end else begin
      quietCnt  <= (&strobeN) ? ((quietCnt  == 3'd7) ? quietCnt  : quietCnt  + 3'd1) : 3'd0;
      enHighCnt <= busEnN     ? ((enHighCnt == 3'd7) ? enHighCnt : enHighCnt + 3'd1) : 3'd0;
      readCnt   <= dirRead    ? ((readCnt   == 3'd7) ? readCnt   : readCnt   + 3'd1) : 3'd0;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (allRegs == '0));

  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt >= 3'd4) |-> $stable(allRegs));

  a_r4_enable_high_hold: assert property (@(posedge clk) disable iff (!rstN)
    (enHighCnt >= 3'd4) |-> $stable(allRegs));

  a_r5_read_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    (readCnt >= 3'd4) |-> $stable(allRegs));
endmodule

bind strobe_bank strobe_bank_chk #(.DATA_W(DATA_W), .NSTB(strobe_bank_pkg::REG_COUNT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busEnN (busEnN),
  .dirRead(dirRead),
  .strobeN(strobeN),
  .sysCtl (sysCtl),
  .monCtl (monCtl),
  .clkCtl (clkCtl)
);

// File: tb/test_strobe_bank.sv
module test_strobe_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busData = 8'hFF;
  logic       busEnN = 1'b1;
  logic       dirRead = 1'b0;
  logic [2:0] strobeN = 3'b111;
  logic [7:0] sysCtl, monCtl, clkCtl;

  int checks = 0;
  int fails = 0;
  logic [7:0] expSys = 8'h00, expMon = 8'h00, expClk = 8'h00;

  always #5 clk = ~clk;

  strobe_bank i_strobe_bank (
    .clk(clk), .rstN(rstN), .busData(busData), .busEnN(busEnN),
    .dirRead(dirRead), .strobeN(strobeN),
    .sysCtl(sysCtl), .monCtl(monCtl), .clkCtl(clkCtl)
  );

  task automatic checkVal(input string req, input string name,
                          input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    checkVal(req, "sysCtl", sysCtl, expSys);
    checkVal(req, "monCtl", monCtl, expMon);
    checkVal(req, "clkCtl", clkCtl, expClk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Full host write sequence; the bus parks at 0xFF afterwards.
  task automatic hostWrite(input logic [2:0] mask, input logic [7:0] val,
                           input logic en, input logic dir);
    busData = val; dirRead = dir; idle(3);
    busEnN = en;                  idle(3);
    strobeN = ~mask;              idle(3);
    strobeN = 3'b111;             idle(3);
    busEnN = 1'b1; busData = 8'hFF; dirRead = 1'b0;
    idle(6);
  endtask

  task automatic doReset();
    rstN = 1'b0; idle(2);
    expSys = 8'h00; expMon = 8'h00; expClk = 8'h00;
    checkAll("R1 during reset");
    rstN = 1'b1; idle(1);
    checkAll("R1 after release");
  endtask

  task automatic t_perRegister();
    hostWrite(3'b001, 8'hA5, 1'b0, 1'b0); expSys = 8'hA5;
    checkAll("R2 R3 system write");
    hostWrite(3'b010, 8'h3C, 1'b0, 1'b0); expMon = 8'h3C;
    checkAll("R2 R3 monitor write");
    hostWrite(3'b100, 8'h81, 1'b0, 1'b0); expClk = 8'h81;
    checkAll("R2 R3 clock write");
  endtask

  task automatic t_latency();
    busData = 8'h0F; busEnN = 1'b0; idle(3);
    strobeN = 3'b110; idle(3);
    strobeN = 3'b111; idle(4);
    expSys = 8'h0F;
    checkAll("R2 within 4 cycles");
    busEnN = 1'b1; busData = 8'hFF; idle(4);
  endtask

  task automatic t_enableHigh();
    hostWrite(3'b001, 8'h11, 1'b1, 1'b0);
    checkAll("R4 enable high");
  endtask

  task automatic t_readDir();
    hostWrite(3'b010, 8'h22, 1'b0, 1'b1);
    checkAll("R5 read direction");
  endtask

  task automatic t_busNoise();
    for (int i = 0; i < 6; i++) begin
      busData = 8'h40 + 8'(i * 17); busEnN = i[0]; idle(2);
    end
    busEnN = 1'b1; busData = 8'hFF; idle(6);
    checkAll("R6 bus activity without strobe");
  endtask

  task automatic t_lateData();
    busData = 8'h10; busEnN = 1'b0; idle(3);
    strobeN = 3'b011; idle(4);
    busData = 8'h77; idle(4);
    strobeN = 3'b111; idle(4);
    busEnN = 1'b1; busData = 8'hFF; idle(4);
    expClk = 8'h77;
    checkAll("R7 value at rising edge");
  endtask

  task automatic t_dual();
    hostWrite(3'b101, 8'h5A, 1'b0, 1'b0);
    expSys = 8'h5A; expClk = 8'h5A;
    checkAll("R8 two strobes together");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    doReset();
    t_perRegister();
    t_latency();
    t_enableHigh();
    t_readDir();
    t_busNoise();
    t_lateData();
    t_dual();
    doReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule